// File: doc/BRIEF.md
# Dual-Pipe Issue Pairing Gate

This block sits after instruction decode in a two-pipe, in-order integer core. The core has a primary pipe U and a secondary pipe V. Each cycle the block sees the two oldest decoded instructions, a first one and a second one in program order. It puts each of them into a pairing class. It then decides whether both issue together, with the first going to U and the second to V, or whether only the first issues. When only the first issues, the second becomes the first instruction of the next cycle.

The class depends on more than the opcode group. Prefix bits, an immediate-with-displacement encoding and the form of the operands (a constant shift count, a rotate by one, a constant call target) can all make an instruction less pairable. A pair is refused when the second instruction depends on a register written by the first. The one exception is stack operations, which use a stack-pointer bypass. A memory-ordering rule also applies: when a paired read-modify-write instruction issues next to another memory reader, the reader is held until the read-modify-write reaches its final cycle, and issue stalls while that hold lasts.

Top module: `pair_gate`

## Requirements
- R1: The class outputs are 2 bits wide: 0 means either pipe (UV), 1 means U only (PU), 2 means V only (PV) and 3 means never paired (NP). An instruction whose immediate-with-displacement flag is set is NP, whatever its kind.
- R2: Kinds 0 to 6 (ALU, single-operand ALU, move, compare, test, address-generate, increment/decrement) are UV. Kinds 7 (push) and 8 (pop) are UV unless their memory code is 3. Any of these kinds that has a prefix bit set is PU. The prefix bits are bit0 for the escape byte, bit1 for operand size and bit2 for repeat. A push or pop with memory code 3 is NP.
- R3: Kind 9 (branch) is PV. Kind 12 (call) is PV when operand-form bit2 (constant target) is set, and NP otherwise.
- R4: Kind 10 (shift) is PU when operand-form bit0 (constant count) is set, and NP otherwise. Kind 11 (rotate) is PU only when operand-form bit1 (count of one) is set, and NP otherwise. Kinds 13 to 15 are NP.
- R5: `issue_pair` is high when all of the following hold: both slots are valid, the first class is UV or PU, the second class is UV or PV, there is no register dependency, and no hold is active.
- R6: There is a register dependency when the first instruction writes `first_dst` and the second instruction reads that register through `second_src`, or writes it through `second_dst` with `second_dst_we` set. The dependency is waived when the first instruction is a push or pop and the second is a push, pop or call.
- R7: `issue_single` is high when the first slot is valid, no pair issues and no hold is active. When only the second slot is valid, nothing issues. The two strobes are never high together.
- R8: Memory codes are 0 none, 1 load, 2 store and 3 load-and-store. A pair where one instruction has code 3 and the other has code 1 or 3 raises `order_hold` for the next LSE_CYCLES-1 cycles, and both strobes stay low during those cycles.
- R9: While reset is asserted and on the first cycle after it, `order_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_vld | input | 1 | First slot holds an instruction |
| first_kind | input | 4 | First instruction kind code |
| first_pfx | input | 3 | First prefix bits: escape, operand size, repeat |
| first_mem | input | 2 | First memory access code |
| first_immdisp | input | 1 | First has both an immediate and a displacement |
| first_opf | input | 3 | First operand forms: constant count, count one, constant target |
| first_dst | input | REG_W | First destination register |
| first_dst_we | input | 1 | First writes its destination |
| first_src | input | REG_W | First source register |
| second_vld | input | 1 | Second slot holds an instruction |
| second_kind | input | 4 | Second instruction kind code |
| second_pfx | input | 3 | Second prefix bits |
| second_mem | input | 2 | Second memory access code |
| second_immdisp | input | 1 | Second has both an immediate and a displacement |
| second_opf | input | 3 | Second operand forms |
| second_dst | input | REG_W | Second destination register |
| second_dst_we | input | 1 | Second writes its destination |
| second_src | input | REG_W | Second source register |
| first_cls | output | 2 | Pairing class of the first instruction |
| second_cls | output | 2 | Pairing class of the second instruction |
| issue_pair | output | 1 | Both issue this cycle, first to U and second to V |
| issue_single | output | 1 | Only the first issues this cycle, into U |
| order_hold | output | 1 | Memory-ordering hold is active and issue is stalled |

## Verification
The bench uses the default parameters, REG_W of 3 and LSE_CYCLES of 3. With only eight registers, random register indices collide often, so the dependency refusal and the stack bypass both come up many times. With a three-cycle read-modify-write, each memory clash gives a two-cycle stall. The bench tracks that stall with its own counter, so it checks both where the hold starts and where it ends, along with the strobes being blocked during it.

// File: rtl/pair_gate.sv
module pair_gate #(
  parameter int REG_W      = 3,
  parameter int LSE_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_vld,
  input  logic [3:0]       first_kind,
  input  logic [2:0]       first_pfx,
  input  logic [1:0]       first_mem,
  input  logic             first_immdisp,
  input  logic [2:0]       first_opf,
  input  logic [REG_W-1:0] first_dst,
  input  logic             first_dst_we,
  input  logic [REG_W-1:0] first_src,
  input  logic             second_vld,
  input  logic [3:0]       second_kind,
  input  logic [2:0]       second_pfx,
  input  logic [1:0]       second_mem,
  input  logic             second_immdisp,
  input  logic [2:0]       second_opf,
  input  logic [REG_W-1:0] second_dst,
  input  logic             second_dst_we,
  input  logic [REG_W-1:0] second_src,
  output logic [1:0]       first_cls,
  output logic [1:0]       second_cls,
  output logic             issue_pair,
  output logic             issue_single,
  output logic             order_hold
);

  localparam logic [1:0] C_UV = 2'd0;
  localparam logic [1:0] C_PU = 2'd1;
  localparam logic [1:0] C_PV = 2'd2;
  localparam logic [1:0] C_NP = 2'd3;
  localparam int CW = (LSE_CYCLES > 2) ? $clog2(LSE_CYCLES) : 1;
  localparam logic [CW-1:0] HOLD_LEN = CW'(LSE_CYCLES - 1);

  function automatic logic [1:0] classify(input logic [3:0] k, input logic [2:0] pfx,
                                          input logic [1:0] mem, input logic immdisp,
                                          input logic [2:0] opf);
    logic [1:0] simple;
    simple = (|pfx) ? C_PU : C_UV;
    if (immdisp) return C_NP;
    case (k)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return simple;
      4'd7, 4'd8: return (mem == 2'd3) ? C_NP : simple;
      4'd9:  return C_PV;
      4'd10: return opf[0] ? C_PU : C_NP;
      4'd11: return opf[1] ? C_PU : C_NP;
      4'd12: return opf[2] ? C_PV : C_NP;
      default: return C_NP;
    endcase
  endfunction

  logic [CW-1:0] hold_cnt;
  logic          busy, stack_bypass, reg_dep, slots_fit, mem_clash;

  assign first_cls  = classify(first_kind, first_pfx, first_mem, first_immdisp, first_opf);
  assign second_cls = classify(second_kind, second_pfx, second_mem, second_immdisp, second_opf);

  assign stack_bypass = (first_kind == 4'd7 || first_kind == 4'd8) &&
                        (second_kind == 4'd7 || second_kind == 4'd8 || second_kind == 4'd12);
  assign reg_dep   = first_dst_we && !stack_bypass &&
                     (second_src == first_dst || (second_dst_we && second_dst == first_dst));
  assign slots_fit = (first_cls == C_UV || first_cls == C_PU) &&
                     (second_cls == C_UV || second_cls == C_PV);
  assign mem_clash = (first_mem == 2'd3 && second_mem[0]) || (second_mem == 2'd3 && first_mem[0]);

  assign busy         = hold_cnt != '0;
  assign issue_pair   = !busy && first_vld && second_vld && slots_fit && !reg_dep;
  assign issue_single = !busy && first_vld && !issue_pair;
  assign order_hold   = busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                       hold_cnt <= '0;
    else if (issue_pair && mem_clash) hold_cnt <= HOLD_LEN;
    else if (busy)                    hold_cnt <= hold_cnt - 1'b1;
  end

  AST_IMMDISP_NP: assert property (@(posedge clk) disable iff (!rst_n)
    first_immdisp |-> first_cls == C_NP); // R1
  AST_PREFIX_NOT_UV: assert property (@(posedge clk) disable iff (!rst_n)
    (|second_pfx) |-> second_cls != C_UV); // R2
  AST_BRANCH_PV: assert property (@(posedge clk) disable iff (!rst_n)
    (first_kind == 4'd9 && !first_immdisp) |-> first_cls == C_PV); // R3
  AST_VARSHIFT_NP: assert property (@(posedge clk) disable iff (!rst_n)
    (first_kind == 4'd10 && !first_opf[0]) |-> first_cls == C_NP); // R4
  AST_NO_NP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> (first_cls != C_NP && second_cls != C_NP && first_vld && second_vld)); // R5
  AST_DEP_ONLY_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pair && first_dst_we && second_src == first_dst) |->
      (first_kind == 4'd7 || first_kind == 4'd8)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_pair && issue_single)); // R7
  AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    order_hold |-> (!issue_pair && !issue_single)); // R8
  AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pair && mem_clash) |=> order_hold); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !order_hold); // R9

endmodule

// File: tb/pair_gate_test.sv
module pair_gate_test;
  localparam int CLK_T = 10;
  localparam int REG_W = 3;
  localparam int LSE   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_vld, s_vld, f_imm, s_imm, f_we, s_we;
  logic [3:0] f_k, s_k;
  logic [2:0] f_pfx, s_pfx, f_opf, s_opf;
  logic [1:0] f_mem, s_mem;
  logic [REG_W-1:0] f_dst, f_src, s_dst, s_src;
  logic [1:0] f_cls, s_cls;
  logic pair, single, hold;

  int tests = 0, fails = 0, model_cnt = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  pair_gate #(.REG_W(REG_W), .LSE_CYCLES(LSE)) uut (
    .clk(clk), .rst_n(rst_n),
    .first_vld(f_vld), .first_kind(f_k), .first_pfx(f_pfx), .first_mem(f_mem),
    .first_immdisp(f_imm), .first_opf(f_opf), .first_dst(f_dst), .first_dst_we(f_we),
    .first_src(f_src),
    .second_vld(s_vld), .second_kind(s_k), .second_pfx(s_pfx), .second_mem(s_mem),
    .second_immdisp(s_imm), .second_opf(s_opf), .second_dst(s_dst), .second_dst_we(s_we),
    .second_src(s_src),
    .first_cls(f_cls), .second_cls(s_cls), .issue_pair(pair), .issue_single(single),
    .order_hold(hold));

  function automatic int exp_cls(int k, int pfx, int mem, int imm, int opf);
    if (imm != 0) return 3;
    if (k <= 6) return (pfx != 0) ? 1 : 0;
    if (k == 7 || k == 8) return (mem == 3) ? 3 : ((pfx != 0) ? 1 : 0);
    if (k == 9) return 2;
    if (k == 10) return opf[0] ? 1 : 3;
    if (k == 11) return opf[1] ? 1 : 3;
    if (k == 12) return opf[2] ? 2 : 3;
    return 3;
  endfunction

  function automatic string cls_tag(int k, int imm);
    if (imm != 0) return "R1";
    if (k <= 8) return "R2";
    if (k == 9 || k == 12) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_first(int v, int k, int pfx, int mem, int imm, int opf, int d, int we, int s);
    f_vld = 1'(v); f_k = 4'(k); f_pfx = 3'(pfx); f_mem = 2'(mem); f_imm = 1'(imm);
    f_opf = 3'(opf); f_dst = REG_W'(d); f_we = 1'(we); f_src = REG_W'(s);
  endtask

  task automatic set_second(int v, int k, int pfx, int mem, int imm, int opf, int d, int we, int s);
    s_vld = 1'(v); s_k = 4'(k); s_pfx = 3'(pfx); s_mem = 2'(mem); s_imm = 1'(imm);
    s_opf = 3'(opf); s_dst = REG_W'(d); s_we = 1'(we); s_src = REG_W'(s);
  endtask

  // inputs already driven after a negedge; sample, then model the edge
  task automatic step();
    int fc, sc, fits, dep, byp, ep, es, clash;
    #1;
    fc = exp_cls(f_k, f_pfx, f_mem, f_imm, f_opf);
    sc = exp_cls(s_k, s_pfx, s_mem, s_imm, s_opf);
    byp = ((f_k == 7 || f_k == 8) && (s_k == 7 || s_k == 8 || s_k == 12)) ? 1 : 0;
    dep = (f_we && byp == 0 && (s_src == f_dst || (s_we && s_dst == f_dst))) ? 1 : 0;
    fits = ((fc == 0 || fc == 1) && (sc == 0 || sc == 2)) ? 1 : 0;
    ep = (model_cnt == 0 && f_vld && s_vld && fits == 1 && dep == 0) ? 1 : 0;
    es = (model_cnt == 0 && f_vld && ep == 0) ? 1 : 0;
    clash = ((f_mem == 3 && s_mem[0]) || (s_mem == 3 && f_mem[0])) ? 1 : 0;
    check(cls_tag(f_k, f_imm), f_cls, fc);
    check(cls_tag(s_k, s_imm), s_cls, sc);
    check((f_we && s_src == f_dst) ? "R6" : "R5", pair, ep);
    check("R7", single, es);
    check("R8", hold, (model_cnt != 0) ? 1 : 0);
    @(posedge clk);
    if (ep == 1 && clash == 1) model_cnt = LSE - 1;
    else if (model_cnt > 0) model_cnt--;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    set_first(0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_second(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R9", hold, 0);
    rst_n = 1'b1;
    check("R9", hold, 0);

    // R2: plain ALU pair, independent
    set_first(1, 0, 0, 0, 0, 0, 1, 1, 2); set_second(1, 2, 0, 0, 0, 0, 3, 1, 4); step();
    // R2: prefixed compare is U only, branch in V pairs
    set_first(1, 3, 4, 0, 0, 0, 1, 0, 2); set_second(1, 9, 0, 0, 0, 0, 3, 0, 4); step();
    // R1: imm+disp forces NP, single issue
    set_first(1, 0, 0, 0, 1, 0, 1, 1, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 4); step();
    // R4: variable shift NP, rotate by one PU
    set_first(1, 10, 0, 0, 0, 0, 1, 1, 2); set_second(1, 11, 0, 0, 0, 2, 3, 1, 4); step();
    set_first(1, 11, 0, 0, 0, 2, 1, 1, 2); set_second(1, 1, 0, 0, 0, 0, 3, 1, 4); step();
    // R3: call with variable target NP, constant target PV
    set_first(1, 1, 0, 0, 0, 0, 1, 1, 2); set_second(1, 12, 0, 0, 0, 0, 3, 0, 4); step();
    set_first(1, 1, 0, 0, 0, 0, 1, 1, 2); set_second(1, 12, 0, 0, 0, 4, 3, 0, 4); step();
    // R5: V-only instruction in first slot refuses
    set_first(1, 9, 0, 0, 0, 0, 1, 0, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 4); step();
    // R6: read-after-write refused, stack bypass allowed
    set_first(1, 2, 0, 0, 0, 0, 5, 1, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 5); step();
    set_first(1, 7, 0, 2, 0, 0, 5, 1, 2); set_second(1, 8, 0, 1, 0, 0, 5, 1, 5); step();
    // R7: second only valid issues nothing
    set_first(0, 0, 0, 0, 0, 0, 1, 1, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 4); step();
    // R8: load-and-store with load, then stall
    set_first(1, 0, 0, 3, 0, 0, 1, 1, 2); set_second(1, 2, 0, 1, 0, 0, 3, 1, 4); step();
    set_first(1, 0, 0, 0, 0, 0, 1, 1, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 4); step();
    step(); step();
    // R8: store next to load-and-store is no clash
    set_first(1, 0, 0, 3, 0, 0, 1, 1, 2); set_second(1, 2, 0, 2, 0, 0, 3, 1, 4); step();
    // R2: push with memory code 3 is NP
    set_first(1, 7, 0, 3, 0, 0, 1, 1, 2); set_second(1, 0, 0, 0, 0, 0, 3, 1, 4); step();

    for (int i = 0; i < 3000; i++) begin
      set_first(($urandom % 8) != 0, $urandom % 16, ($urandom % 3 == 0) ? $urandom % 8 : 0,
                $urandom % 4, ($urandom % 8) == 0, $urandom % 8, $urandom % 8,
                $urandom % 2, $urandom % 8);
      set_second(($urandom % 8) != 0, $urandom % 16, ($urandom % 3 == 0) ? $urandom % 8 : 0,
                 $urandom % 4, ($urandom % 8) == 0, $urandom % 8, $urandom % 8,
                 $urandom % 2, $urandom % 8);
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule